// File: doc/BRIEF.md
# CSR Transition Coverage Monitor

This monitor sits beside a processor core and watches four privileged control and status registers (CSRs) at every retired instruction. When a register's value at one retirement differs from its value at the previous retirement, the pair (old value, new value) counts as a transition. Each transition is reduced to a signature index into a fixed bitmap of seen transitions. A transition whose bitmap bit is still clear is new. It raises a one-cycle pulse and advances a saturating count of unique transitions. A fuzzing harness uses that pulse to decide whether a test input earns a full RTL run and a comparison of traces.

Every retirement also produces a trace record. It carries the retired PC and the four register values, so the harness can build an extended execution trace. A synchronous clear empties the seen-set and the count between test inputs. After the clear, the next retirement only sets a new baseline.

Top module: `csrcov_monitor`

## Requirements
- R1: While `rstN` is low, and in the first cycle after it rises, `newPulse` and `traceValid` are 0 and `uniqueCount` is 0.
- R2: A retirement (`retValid`=1, `clear`=0) at a clock edge gives `traceValid`=1 in the following cycle, with `tracePc` and `traceCsr` equal to the sampled `retPc` and `csrVals`. Any other cycle gives `traceValid`=0 in the following cycle.
- R3: The first retirement after reset or after a clear only records a baseline. It causes no pulse and no change of count.
- R4: A lane whose value equals its value at the previous retirement contributes nothing. A cycle without a retirement leaves the baseline untouched and gives no pulse.
- R5: `csrVals` packs lane k in bits [32k+31:32k]. Lane 0 is the machine scratch register, lane 1 the machine exception PC, lane 2 the supervisor exception PC and lane 3 the supervisor scratch register. For a changed lane k, the signature is s = prev XOR rotl(new,3) XOR k. Its index is s[9:0]^s[19:10]^s[29:20]^{8'b0,s[31:30]}. Two transitions with the same index are the same transition.
- R6: A changed lane whose index bit is clear is new. In the cycle after the retirement, `newPulse`=1 and `uniqueCount` has risen by one. The bit is then set, and a later transition with the same index gives no pulse.
- R7: Several changed lanes in one retirement are each checked. One pulse is raised if any of them is new, and the count rises by the number of distinct new indices. Two lanes with the same new index in one retirement count once.
- R8: `clear` high at an edge empties the bitmap and zeroes the count in that single cycle. A retirement presented in the same cycle is discarded: it gives no trace record and no baseline. The cycle after the clear shows `uniqueCount`=0 and `newPulse`=0.
- R9: `uniqueCount` saturates at 2^CNT_W-1 and does not wrap. Pulses for new transitions still occur while the count is saturated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| clear | input | 1 | Empty the seen-set and the count |
| retValid | input | 1 | An instruction retires this cycle |
| retPc | input | XLEN | PC of the retiring instruction |
| csrVals | input | NUM_CSR*XLEN | Current values of the monitored CSRs, lane 0 lowest |
| newPulse | output | 1 | The previous retirement produced an unseen transition |
| uniqueCount | output | CNT_W | Saturating count of unique transitions |
| traceValid | output | 1 | A trace record is present |
| tracePc | output | XLEN | PC of the trace record |
| traceCsr | output | NUM_CSR*XLEN | CSR values of the trace record |

## Verification
Two situations are the hardest to reach from the ports. The first is two lanes changing in one retirement onto the same unseen index. The second is a never-seen value pair that aliases onto an index that is already set. The stimulus reaches both with small register values. Below 128 the fold leaves prev XOR (new<<3) XOR lane untouched, so indices can be placed exactly: lanes 1 and 3 both land on index 35, and a high-bit value on lane 0 lands on index 1. Saturation comes from a long run of single-lane changes, checked against a bench model of the bitmap with a narrow count.

// File: rtl/csrcov_pkg.sv
package csrcov_pkg;

  typedef struct packed {
    logic clear;    // empty bitmap and counter
    logic capture;  // latch current CSR values as the new baseline
    logic eval;     // compare current values against the baseline
    logic trace;    // emit a trace record
  } covStrobe_t;

endpackage

// File: rtl/csrcov_ctrl.sv
module csrcov_ctrl
  import csrcov_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       clear,
  input  logic       retValid,
  output covStrobe_t strobe
);

  logic baseValid;
  logic accept;

  assign accept = retValid && !clear;

  always_comb begin
    strobe.clear   = clear;
    strobe.capture = accept;
    strobe.eval    = accept && baseValid;
    strobe.trace   = accept;
  end

  always_ff @(posedge clk) begin
    if (!rstN)       baseValid <= 1'b0;
    else if (clear)  baseValid <= 1'b0;
    else if (accept) baseValid <= 1'b1;
  end

  // R3
  baseline_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    clear |=> !strobe.eval);

endmodule

// File: rtl/csrcov_dp.sv
module csrcov_dp
  import csrcov_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int NUM_CSR = 4,
  parameter int IDX_W   = 10,
  parameter int CNT_W   = 16,
  parameter int ROT     = 3
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  covStrobe_t                strobe,
  input  logic [XLEN-1:0]           retPc,
  input  logic [NUM_CSR*XLEN-1:0]   csrVals,
  output logic                      newPulse,
  output logic [CNT_W-1:0]          uniqueCount,
  output logic                      traceValid,
  output logic [XLEN-1:0]           tracePc,
  output logic [NUM_CSR*XLEN-1:0]   traceCsr
);

  localparam int DEPTH  = 1 << IDX_W;
  localparam int NCHUNK = (XLEN + IDX_W - 1) / IDX_W;
  localparam int PAD_W  = NCHUNK * IDX_W;
  localparam int NEW_W  = $clog2(NUM_CSR + 1);
  localparam int SUM_W  = CNT_W + NEW_W;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [XLEN-1:0]  prevCsr [NUM_CSR];
  logic [DEPTH-1:0] bitmap, bitmapNext;
  logic [IDX_W-1:0] laneIdx [NUM_CSR];
  logic [NUM_CSR-1:0] changed, seenHit, dupLane, isNew;
  logic [NEW_W-1:0] newCount;
  logic [SUM_W-1:0] sumWide;

  // per-lane signature and fold
  for (genvar g = 0; g < NUM_CSR; g++) begin : laneGen
    logic [XLEN-1:0]  cur, rot, sig;
    logic [PAD_W-1:0] padded;
    logic [IDX_W-1:0] fold;

    assign cur    = csrVals[g*XLEN +: XLEN];
    assign rot    = {cur[XLEN-ROT-1:0], cur[XLEN-1:XLEN-ROT]};
    assign sig    = prevCsr[g] ^ rot ^ XLEN'(g);
    assign padded = PAD_W'(sig);

    always_comb begin
      fold = '0;
      for (int k = 0; k < NCHUNK; k++) fold ^= padded[k*IDX_W +: IDX_W];
    end

    assign laneIdx[g] = fold;
    assign changed[g] = strobe.eval && (cur != prevCsr[g]);
    assign seenHit[g] = bitmap[fold];
  end

  // a lower lane with the same index in this retirement already claims it
  always_comb begin
    for (int i = 0; i < NUM_CSR; i++) begin
      dupLane[i] = 1'b0;
      for (int j = 0; j < i; j++)
        if (changed[j] && laneIdx[j] == laneIdx[i]) dupLane[i] = 1'b1;
    end
    isNew = changed & ~seenHit & ~dupLane;
  end

  always_comb begin
    newCount = '0;
    for (int i = 0; i < NUM_CSR; i++) newCount += NEW_W'(isNew[i]);
    sumWide = SUM_W'(uniqueCount) + SUM_W'(newCount);
  end

  always_comb begin
    bitmapNext = bitmap;
    for (int i = 0; i < NUM_CSR; i++)
      if (changed[i]) bitmapNext[laneIdx[i]] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clear) begin
      bitmap      <= '0;
      uniqueCount <= '0;
      newPulse    <= 1'b0;
    end else begin
      bitmap   <= bitmapNext;
      newPulse <= |isNew;
      if (sumWide > SUM_W'(CNT_MAX)) uniqueCount <= CNT_MAX;
      else                           uniqueCount <= sumWide[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.capture)
      for (int i = 0; i < NUM_CSR; i++) prevCsr[i] <= csrVals[i*XLEN +: XLEN];
  end

  always_ff @(posedge clk) begin
    if (!rstN) traceValid <= 1'b0;
    else       traceValid <= strobe.trace;
    if (strobe.trace) begin
      tracePc  <= retPc;
      traceCsr <= csrVals;
    end
  end

  // R8
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear |=> (uniqueCount == '0 && !newPulse));

  // R9
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.clear |=> uniqueCount >= $past(uniqueCount));

  // R6
  pulse_counted_chk: assert property (@(posedge clk) disable iff (!rstN)
    newPulse |-> (uniqueCount > $past(uniqueCount) || uniqueCount == CNT_MAX));

  // R2
  trace_follows_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.trace |=> traceValid);

endmodule

// File: rtl/csrcov_monitor.sv
module csrcov_monitor
  import csrcov_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int NUM_CSR = 4,
  parameter int IDX_W   = 10,
  parameter int CNT_W   = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    clear,
  input  logic                    retValid,
  input  logic [XLEN-1:0]         retPc,
  input  logic [NUM_CSR*XLEN-1:0] csrVals,
  output logic                    newPulse,
  output logic [CNT_W-1:0]        uniqueCount,
  output logic                    traceValid,
  output logic [XLEN-1:0]         tracePc,
  output logic [NUM_CSR*XLEN-1:0] traceCsr
);

  covStrobe_t strobe;

  csrcov_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .clear    (clear),
    .retValid (retValid),
    .strobe   (strobe)
  );

  csrcov_dp #(
    .XLEN    (XLEN),
    .NUM_CSR (NUM_CSR),
    .IDX_W   (IDX_W),
    .CNT_W   (CNT_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .retPc       (retPc),
    .csrVals     (csrVals),
    .newPulse    (newPulse),
    .uniqueCount (uniqueCount),
    .traceValid  (traceValid),
    .tracePc     (tracePc),
    .traceCsr    (traceCsr)
  );

  // R4
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !retValid |=> (!newPulse && !traceValid));

  // R4
  unchanged_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (retValid && !clear && $past(retValid) && !$past(clear) && $stable(csrVals))
      |=> !newPulse);

endmodule

// File: tb/sim_csrcov_monitor.sv
module sim_csrcov_monitor;

  localparam int XLEN = 32;
  localparam int NC   = 4;
  localparam int CW   = 5;

  logic clk = 1'b0;
  logic rstN, clear, retValid;
  logic [XLEN-1:0] retPc;
  logic [NC*XLEN-1:0] csrVals;
  logic newPulse, traceValid;
  logic [CW-1:0] uniqueCount;
  logic [XLEN-1:0] tracePc;
  logic [NC*XLEN-1:0] traceCsr;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;  // 125 MHz

  csrcov_monitor #(.XLEN(XLEN), .NUM_CSR(NC), .IDX_W(10), .CNT_W(CW)) u0 (
    .clk(clk), .rstN(rstN), .clear(clear), .retValid(retValid),
    .retPc(retPc), .csrVals(csrVals), .newPulse(newPulse),
    .uniqueCount(uniqueCount), .traceValid(traceValid),
    .tracePc(tracePc), .traceCsr(traceCsr)
  );

  typedef struct packed {
    logic        clr;
    logic        ret;
    logic [31:0] pc;
    logic [31:0] v0, v1, v2, v3;
    logic        expP;
    logic [4:0]  expN;
    logic        expT;
  } vec_t;

  // index of a small transition = prev ^ (new<<3) ^ lane
  localparam vec_t VEC [14] = '{
    '{1'b0, 1'b1, 32'h100, 32'd0,   32'd0, 32'd0, 32'd0, 1'b0, 5'd0, 1'b1}, // R3 baseline
    '{1'b0, 1'b1, 32'h104, 32'd0,   32'd0, 32'd0, 32'd0, 1'b0, 5'd0, 1'b1}, // R4 unchanged
    '{1'b0, 1'b1, 32'h108, 32'd1,   32'd0, 32'd0, 32'd0, 1'b1, 5'd1, 1'b1}, // R6 idx 8
    '{1'b0, 1'b1, 32'h10c, 32'd0,   32'd0, 32'd0, 32'd0, 1'b1, 5'd2, 1'b1}, // R6 idx 1
    '{1'b0, 1'b1, 32'h110, 32'd1,   32'd0, 32'd0, 32'd0, 1'b0, 5'd2, 1'b1}, // R6 repeat idx 8
    '{1'b0, 1'b0, 32'h114, 32'd5,   32'd5, 32'd5, 32'd5, 1'b0, 5'd2, 1'b0}, // R4 no retire
    '{1'b0, 1'b1, 32'h118, 32'd1,   32'd2, 32'd2, 32'd0, 1'b1, 5'd4, 1'b1}, // R7 idx 17,18
    '{1'b0, 1'b1, 32'h11c, 32'd1,   32'd2, 32'd2, 32'd0, 1'b0, 5'd4, 1'b1}, // R4
    '{1'b0, 1'b1, 32'h120, 32'd1,   32'd4, 32'd2, 32'd4, 1'b1, 5'd5, 1'b1}, // R7 both idx 35
    '{1'b1, 1'b1, 32'h124, 32'd9,   32'd9, 32'd9, 32'd9, 1'b0, 5'd0, 1'b0}, // R8 clear
    '{1'b0, 1'b1, 32'h128, 32'd1,   32'd4, 32'd2, 32'd4, 1'b0, 5'd0, 1'b1}, // R3 after clear
    '{1'b0, 1'b1, 32'h12c, 32'd0,   32'd4, 32'd2, 32'd4, 1'b1, 5'd1, 1'b1}, // R8 idx 1 new again
    '{1'b0, 1'b1, 32'h130, 32'd128, 32'd4, 32'd2, 32'd4, 1'b0, 5'd1, 1'b1}, // R5 alias idx 1
    '{1'b0, 1'b1, 32'h134, 32'd0,   32'd4, 32'd2, 32'd4, 1'b1, 5'd2, 1'b1}  // R5 idx 128
  };

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic c, input logic r, input logic [31:0] pc,
                      input logic [31:0] v0, v1, v2, v3);
    clear = c; retValid = r; retPc = pc; csrVals = {v3, v2, v1, v0};
    @(negedge clk);
  endtask

  function automatic logic [9:0] hashIdx(input logic [31:0] p, input logic [31:0] n, input int lane);
    logic [31:0] s;
    s = p ^ {n[28:0], n[31:29]} ^ 32'(lane);
    return s[9:0] ^ s[19:10] ^ s[29:20] ^ {8'b0, s[31:30]};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic seen [1024];
    int modelCnt;
    logic [31:0] prev0;
    rstN = 1'b0; clear = 1'b0; retValid = 1'b1; retPc = '0; csrVals = '1;
    repeat (3) @(negedge clk);
    chk("R1 pulse in reset", 128'(newPulse), 128'(0));
    chk("R1 trace in reset", 128'(traceValid), 128'(0));
    chk("R1 count in reset", 128'(uniqueCount), 128'(0));
    retValid = 1'b0;
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 count after reset", 128'(uniqueCount), 128'(0));
    chk("R1 trace after reset", 128'(traceValid), 128'(0));

    for (int i = 0; i < 14; i++) begin
      step(VEC[i].clr, VEC[i].ret, VEC[i].pc, VEC[i].v0, VEC[i].v1, VEC[i].v2, VEC[i].v3);
      chk($sformatf("R6/R7 pulse row %0d", i), 128'(newPulse), 128'(VEC[i].expP));
      chk($sformatf("R9 count row %0d", i), 128'(uniqueCount), 128'(VEC[i].expN));
      chk($sformatf("R2 trace valid row %0d", i), 128'(traceValid), 128'(VEC[i].expT));
      if (VEC[i].expT) begin
        chk($sformatf("R2 trace pc row %0d", i), 128'(tracePc), 128'(VEC[i].pc));
        chk($sformatf("R2 trace csr row %0d", i), 128'(traceCsr),
            128'({VEC[i].v3, VEC[i].v2, VEC[i].v1, VEC[i].v0}));
      end
    end

    // R8: clear with no retirement, then R3 baseline and R9 saturation run
    step(1'b1, 1'b0, 32'h200, 32'd0, 32'd4, 32'd2, 32'd4);
    chk("R8 count after clear", 128'(uniqueCount), 128'(0));
    step(1'b0, 1'b1, 32'h204, 32'd0, 32'd4, 32'd2, 32'd4);
    chk("R3 baseline pulse", 128'(newPulse), 128'(0));
    for (int i = 0; i < 1024; i++) seen[i] = 1'b0;
    modelCnt = 0;
    prev0 = 32'd0;
    for (int k = 1; k <= 60; k++) begin
      logic [31:0] nv;
      logic [9:0] ix;
      logic expNew;
      nv = 32'(k) * 32'h0001_0203;
      ix = hashIdx(prev0, nv, 0);
      expNew = !seen[ix];
      seen[ix] = 1'b1;
      if (expNew && modelCnt < 31) modelCnt++;
      step(1'b0, 1'b1, 32'h300 + 32'(k), nv, 32'd4, 32'd2, 32'd4);
      chk($sformatf("R5 pulse step %0d", k), 128'(newPulse), 128'(expNew));
      chk($sformatf("R9 count step %0d", k), 128'(uniqueCount), 128'(modelCnt));
      prev0 = nv;
    end
    chk("R9 saturated", 128'(uniqueCount), 128'(31));

    step(1'b0, 1'b0, 32'h0, 32'd0, 32'd0, 32'd0, 32'd0);
    chk("R4 idle no pulse", 128'(newPulse), 128'(0));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule